// File: doc/BRIEF.md
# Dual-Output Flow Key Hasher

This block turns a 112-bit flow key into two CRC values in one step. The key is made of the source and destination IPv4 addresses, the source and destination transport ports, the protocol number and the type-of-service byte. The first value is a 21-bit table index. The second value is a 42-bit signature. The signature is stored with a table entry and later confirms that the entry belongs to the same key.

Each CRC has its own fixed generator polynomial and its own seed register. Software can rewrite either seed at run time through a small write-only configuration port. This makes the key-to-slot mapping hard for an outsider to predict. Keys enter through a valid/ready handshake. Results leave from one output register that has a valid flag and a consumer ready.

Top module: `flow_hash_dual`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Both seeds start as all ones.
- R2: The key is `{src_ip, dst_ip, src_port, dst_port, proto, tos}`, fed most significant bit first. `out_addr` is the CRC of this key with width 21 and polynomial 0x1A4C2D, starting from the address seed. Each step is: shift left, and XOR the polynomial when the old top bit XOR the key bit is 1. No final XOR is applied.
- R3: `out_sig` is the same CRC with width 42 and polynomial 0x1D19C4B7A35, starting from the signature seed.
- R4: A key accepted at a clock edge (`in_valid` and `in_ready` both high) appears on `out_valid`, `out_addr` and `out_sig` right after that same edge.
- R5: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the outputs hold their values.
- R6: While `out_ready` is 1, `in_ready` stays 1, so a new key is accepted on every clock.
- R7: A write with `cfg_we`=1 replaces one seed. `cfg_sel`=0 selects the address seed, which takes `cfg_data[20:0]`. `cfg_sel`=1 selects the signature seed, which takes all 42 bits. The seed that is not selected keeps its value. The new seed is used for keys accepted after the write edge.
- R8: A key accepted at the same edge as a seed write is hashed with the old seed.
- R9: With unchanged seeds, the same key always gives the same pair of hashes.
- R10: If `out_ready` is 1 and `in_valid` is 0, `out_valid` is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Key present |
| in_ready | output | 1 | Key can be accepted |
| src_ip | input | 32 | Source IPv4 address |
| dst_ip | input | 32 | Destination IPv4 address |
| src_port | input | 16 | Source port |
| dst_port | input | 16 | Destination port |
| proto | input | 8 | Transport protocol number |
| tos | input | 8 | Type of service |
| cfg_we | input | 1 | Seed write strobe |
| cfg_sel | input | 1 | 0 selects the address seed, 1 selects the signature seed |
| cfg_data | input | 42 | New seed value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 21 | Table index hash |
| out_sig | output | 42 | Ownership signature hash |

## Verification
Every result is due exactly one edge after its key is accepted. The bench drives inputs on the falling edge and checks them on the next falling edge, which is half a cycle after the registering edge.

A seed write affects results one key later than a key sampled at the same edge. The bench checks both of those keys.

During backpressure, the held result and the low `in_ready` are checked on several falling edges in a row. The key that was waiting is then checked one edge after `out_ready` returns.

// File: rtl/flowhash_pkg.sv
package flowhash_pkg;
    localparam int KEY_W  = 112;
    localparam int ADDR_W = 21;
    localparam int SIG_W  = 42;
    localparam logic [ADDR_W-1:0] ADDR_POLY      = 21'h1A4C2D;
    localparam logic [SIG_W-1:0]  SIG_POLY       = 42'h1D19C4B7A35;
    localparam logic [ADDR_W-1:0] ADDR_SEED_INIT = '1;
    localparam logic [SIG_W-1:0]  SIG_SEED_INIT  = '1;

    typedef struct packed {
        logic [31:0] src_ip;
        logic [31:0] dst_ip;
        logic [15:0] src_port;
        logic [15:0] dst_port;
        logic [7:0]  proto;
        logic [7:0]  tos;
    } flow_key_t;
endpackage

// File: rtl/crc_unit.sv
module crc_unit #(
    parameter int          DATA_W = 112,
    parameter int          W      = 21,
    parameter logic [W-1:0] POLY  = '1
) (
    input  logic [DATA_W-1:0] data,
    input  logic [W-1:0]      seed,
    output logic [W-1:0]      crc
);
    logic [W-1:0] acc;
    logic         fb;

    always_comb begin
        acc = seed;
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[W-1] ^ data[i];
            acc = {acc[W-2:0], 1'b0};
            if (fb) acc = acc ^ POLY;
        end
        crc = acc;
    end
endmodule

// File: rtl/seed_store.sv
module seed_store #(
    parameter int              AW        = 21,
    parameter int              SW        = 42,
    parameter logic [AW-1:0]   AINIT     = '1,
    parameter logic [SW-1:0]   SINIT     = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          sel,
    input  logic [SW-1:0] wdata,
    output logic [AW-1:0] addr_seed,
    output logic [SW-1:0] sig_seed
);
    typedef struct packed {
        logic [AW-1:0] a;
        logic [SW-1:0] s;
    } seeds_t;

    seeds_t seeds_d, seeds_q;

    always_comb begin
        seeds_d = seeds_q;
        if (we) begin
            if (sel) seeds_d.s = wdata;
            else     seeds_d.a = wdata[AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seeds_q.a <= AINIT;
            seeds_q.s <= SINIT;
        end else begin
            seeds_q <= seeds_d;
        end
    end

    assign addr_seed = seeds_q.a;
    assign sig_seed  = seeds_q.s;

    // R7
    seed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(seeds_q));

    // R7
    seed_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel) |=> $stable(seeds_q.a));
endmodule

// File: rtl/flow_hash_dual.sv
module flow_hash_dual
    import flowhash_pkg::*;
#(
    parameter int                 AW        = ADDR_W,
    parameter int                 SW        = SIG_W,
    parameter logic [AW-1:0]      A_POLY    = ADDR_POLY,
    parameter logic [SW-1:0]      S_POLY    = SIG_POLY,
    parameter logic [AW-1:0]      A_INIT    = ADDR_SEED_INIT,
    parameter logic [SW-1:0]      S_INIT    = SIG_SEED_INIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [31:0]   src_ip,
    input  logic [31:0]   dst_ip,
    input  logic [15:0]   src_port,
    input  logic [15:0]   dst_port,
    input  logic [7:0]    proto,
    input  logic [7:0]    tos,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [SW-1:0] cfg_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_addr,
    output logic [SW-1:0] out_sig
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [SW-1:0] sig;
    } res_t;

    flow_key_t     key;
    logic [AW-1:0] a_seed, a_crc;
    logic [SW-1:0] s_seed, s_crc;
    logic          accept;
    res_t          res_d, res_q;

    assign key = '{src_ip: src_ip, dst_ip: dst_ip, src_port: src_port,
                   dst_port: dst_port, proto: proto, tos: tos};

    seed_store #(.AW(AW), .SW(SW), .AINIT(A_INIT), .SINIT(S_INIT)) i_seeds (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_data),
        .addr_seed(a_seed), .sig_seed(s_seed)
    );

    crc_unit #(.DATA_W(KEY_W), .W(AW), .POLY(A_POLY)) i_crc_addr (
        .data(key), .seed(a_seed), .crc(a_crc)
    );

    crc_unit #(.DATA_W(KEY_W), .W(SW), .POLY(S_POLY)) i_crc_sig (
        .data(key), .seed(s_seed), .crc(s_crc)
    );

    assign in_ready = !res_q.vld || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        res_d = res_q;
        if (accept) begin
            res_d.vld  = 1'b1;
            res_d.addr = a_crc;
            res_d.sig  = s_crc;
        end else if (out_ready) begin
            res_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign out_addr  = res_q.addr;
    assign out_sig   = res_q.sig;

    // R4
    accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_sig)));

    // R10
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !in_valid) |=> !out_valid);

    // R6
    no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);
endmodule

// File: tb/test_flow_hash_dual.sv
module test_flow_hash_dual;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] A_POLY = 64'h1A4C2D;
    localparam logic [63:0] S_POLY = 64'h1D19C4B7A35;
    localparam int NVEC = 6;
    localparam logic [111:0] VEC [NVEC] = '{
        112'h0,
        {112{1'b1}},
        {32'hC0A80001, 32'h0A000002, 16'd443, 16'd51000, 8'd6, 8'h00},
        {32'hC0A80001, 32'h0A000002, 16'd443, 16'd51001, 8'd6, 8'h00},
        {32'h08080808, 32'hAC100A05, 16'd53, 16'd40000, 8'd17, 8'hB8},
        {32'h00000001, 32'h80000000, 16'h0001, 16'h8000, 8'h01, 8'h80}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [41:0] cfg_data = '0;
    logic [31:0] src_ip = '0, dst_ip = '0;
    logic [15:0] src_port = '0, dst_port = '0;
    logic [7:0]  proto = '0, tos = '0;
    logic        in_ready, out_valid;
    logic [20:0] out_addr;
    logic [41:0] out_sig;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [63:0] sa = 64'h1FFFFF, ss = 64'h3FFFFFFFFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    flow_hash_dual i_flow_hash_dual (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_ip(src_ip), .dst_ip(dst_ip), .src_port(src_port), .dst_port(dst_port),
        .proto(proto), .tos(tos), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_sig(out_sig)
    );

    function automatic logic [63:0] ref_crc(input logic [111:0] k, input logic [63:0] seed,
                                            input int w, input logic [63:0] poly);
        logic [63:0] m, r;
        logic top;
        m = (64'd1 << w) - 64'd1;
        r = seed & m;
        for (int b = 0; b < 112; b++) begin
            top = r[w-1] ^ k[111-b];
            r = (r << 1) & m;
            if (top) r = r ^ poly;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_key(input logic [111:0] k);
        {src_ip, dst_ip, src_port, dst_port, proto, tos} = k;
    endtask

    task automatic chk_result(input logic [111:0] k, input string req);
        logic [63:0] ea, es;
        ea = ref_crc(k, sa, 21, A_POLY);
        es = ref_crc(k, ss, 42, S_POLY);
        chk(out_valid === 1'b1, req, {63'd0, out_valid}, 64'd1);
        chk({43'd0, out_addr} === ea, req, {43'd0, out_addr}, ea);
        chk({22'd0, out_sig} === es, req, {22'd0, out_sig}, es);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [111:0] ka, kb;
        logic [63:0] old_a, old_s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid === 1'b0, "R1", {63'd0, out_valid}, 64'd0);
        chk(in_ready === 1'b1, "R1", {63'd0, in_ready}, 64'd1);

        // R2 R3 R4 R6: back-to-back vectors, default seeds (R1)
        out_ready = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            put_key(VEC[i]);
            in_valid = 1'b1;
            @(negedge clk);
            chk_result(VEC[i], "R2/R3/R4");
            chk(in_ready === 1'b1, "R6", {63'd0, in_ready}, 64'd1);
        end

        // R9 same key again
        put_key(VEC[2]);
        @(negedge clk);
        chk_result(VEC[2], "R9");

        // R10 idle drop
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R10", {63'd0, out_valid}, 64'd0);

        // R5 backpressure
        ka = VEC[4]; kb = VEC[5];
        out_ready = 1'b0;
        put_key(ka); in_valid = 1'b1;
        @(negedge clk);
        put_key(kb);
        for (int j = 0; j < 3; j++) begin
            chk(in_ready === 1'b0, "R5", {63'd0, in_ready}, 64'd0);
            chk_result(ka, "R5");
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk_result(kb, "R5");
        in_valid = 1'b0;
        @(negedge clk);

        // R7 R8 address seed write together with a key
        old_a = sa;
        put_key(VEC[3]); in_valid = 1'b1;
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_data = 42'h3FF_0012_3456;
        @(negedge clk);
        cfg_we = 1'b0;
        chk_result(VEC[3], "R8");
        sa = 64'h12_3456 & 64'h1FFFFF;
        @(negedge clk);
        chk_result(VEC[3], "R7");
        chk({43'd0, out_addr} !== ref_crc(VEC[3], old_a, 21, A_POLY), "R7",
            {43'd0, out_addr}, ref_crc(VEC[3], sa, 21, A_POLY));

        // R7 R8 signature seed write
        old_s = ss;
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_data = 42'h15A_5A5A_0F0F;
        put_key(VEC[2]);
        @(negedge clk);
        cfg_we = 1'b0;
        chk_result(VEC[2], "R8");
        ss = 64'h15A_5A5A_0F0F;
        @(negedge clk);
        chk_result(VEC[2], "R7");
        chk({22'd0, out_sig} !== ref_crc(VEC[2], old_s, 42, S_POLY), "R7",
            {22'd0, out_sig}, ref_crc(VEC[2], ss, 42, S_POLY));

        // R9 repeat under new seeds
        @(negedge clk);
        chk_result(VEC[2], "R9");
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R10", {63'd0, out_valid}, 64'd0);
        finish_run();
    end
endmodule